// File: doc/BRIEF.md
# Two-Channel Bus Selector with I2C Control

This block is an I2C target that owns a small control register choosing which of two downstream bus channels are joined to the upstream bus. A fast system clock oversamples the upstream SCL and SDA lines. The block finds START and STOP conditions, receives the address and data bytes, and acknowledges by pulling SDA low through an open-drain output enable. A controller can write the register and can read it back. Each bit of the applied register drives one channel-enable output. The enables stand in for the analog switches.

A new selection is held as pending after the write. It reaches the enable outputs only when the next STOP condition is seen. This lets a controller finish its transaction on the upstream segment before the topology changes. The block also merges the two active-low channel interrupt lines into one active-low output. A separate active-low bus-recovery input returns the bus logic to idle and disconnects every channel.

Top module: `bus_chan_selector`

## Requirements
- R1: Bit 0 of an applied control byte enables channel 0 (`chanEn[0]`) and bit 1 enables channel 1 (`chanEn[1]`). Every combination is allowed: 00, 01, 10 and 11.
- R2: A written byte is staged and changes `chanEn` only when a STOP condition (SDA rising while SCL is high) follows the write. A repeated START keeps the staged value pending, and a read in the same transaction still returns the value applied before.
- R3: While the power-on reset `rstN` is low, and after it, all channels are deselected and SDA is released (`sdaOe` = 0).
- R4: While `busRstN` is low, the bus logic returns to idle, `chanEn` is cleared, SDA is released and any staged byte is discarded. A later STOP applies nothing, and the next transaction is handled normally.
- R5: `intOutN` is low whenever at least one bit of `intN` is low, and high only when both are high. Both inputs may be low together.
- R6: The 7-bit address is the 5-bit parameter `ADDR_PREFIX` followed by `addrPins[1:0]`, then the R/W bit (0 = write, 1 = read). Only a matching address is acknowledged (SDA held low in the ninth clock). A transaction with another address leaves the register unchanged.
- R7: Every data byte written to a matched address is acknowledged. When several bytes are written before STOP, the last complete byte is the one applied. A byte cut short by a START or STOP is discarded.
- R8: A read returns the applied register, MSB first, with unused upper bits reading 0. It keeps sending the same value while the controller acknowledges. SDA changes only while SCL is low, and SDA is released after the controller's NACK.
- R9: START (SDA falling while SCL is high) is recognised in any state, including in the middle of a byte. It restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| busRstN | input | 1 | Active-low bus-recovery reset, sampled on clk |
| sclIn | input | 1 | Upstream SCL level |
| sdaIn | input | 1 | Upstream SDA level (wired bus value) |
| sdaOe | output | 1 | Open-drain enable: 1 pulls SDA low |
| addrPins | input | 2 | Low two address bits |
| intN | input | 2 | Active-low interrupt from each channel |
| intOutN | output | 1 | Merged active-low interrupt |
| chanEn | output | 2 | Per-channel switch enable |

## Verification
The bench checks the outputs between a data byte and its STOP. A design that applies the byte at once, or on the repeated START, shows the new enables too early. A read issued in that same window must return the old value. The bench cuts a byte short with a repeated START after four bits. A design that keeps those partial bits would apply a mix of the two bytes rather than the last whole one. It also pulls the recovery reset low during a transaction that has a byte staged. A design that clears only the register would still apply the staged byte at the following STOP. Address-pin changes, multi-byte reads that end in a NACK, and all four interrupt combinations are covered as well. A design that compares the wrong address bits, holds SDA after the NACK, or ORs the interrupt lines the wrong way gives a wrong value at the ports.

// File: rtl/chansel_pkg.sv
package chansel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_MACK
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ackOn;
    logic sdaRelease;
    logic stage;
    logic commit;
    logic busClear;
  } dpCmd_t;

  // events and decoded status from datapath to control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
    logic addrHit;
    logic rwBit;
  } busEv_t;

endpackage

// File: rtl/chansel_ctrl.sv
module chansel_ctrl
  import chansel_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   busRstN,
  input  busEv_t ev,
  output dpCmd_t cmd
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_BITS);

  busState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;
  logic isRead, isReadNxt;

  always_comb begin
    cmd       = '0;
    stateNxt  = state;
    bitCntNxt = bitCnt;
    isReadNxt = isRead;
    if (!busRstN) begin
      cmd.busClear = 1'b1;
      stateNxt     = ST_IDLE;
      bitCntNxt    = '0;
      isReadNxt    = 1'b0;
    end else if (ev.startEv) begin
      cmd.sdaRelease = 1'b1;
      stateNxt       = ST_ADDR;
      bitCntNxt      = '0;
    end else if (ev.stopEv) begin
      cmd.sdaRelease = 1'b1;
      cmd.commit     = 1'b1;
      stateNxt       = ST_IDLE;
      bitCntNxt      = '0;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (ev.sclRise && bitCnt != LAST_CNT) begin
            cmd.rxShift = 1'b1;
            bitCntNxt   = bitCnt + 1'b1;
          end else if (ev.sclFall && bitCnt == LAST_CNT) begin
            bitCntNxt = '0;
            if (state == ST_WDATA) begin
              cmd.ackOn = 1'b1;
              cmd.stage = 1'b1;
              stateNxt  = ST_ACK;
            end else if (ev.addrHit) begin
              cmd.ackOn = 1'b1;
              isReadNxt = ev.rwBit;
              stateNxt  = ST_ACK;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            bitCntNxt = '0;
            if (isRead) begin
              cmd.txLoad = 1'b1;
              stateNxt   = ST_TX;
            end else begin
              cmd.sdaRelease = 1'b1;
              stateNxt       = ST_WDATA;
            end
          end
        end
        ST_TX: begin
          if (ev.sclRise) begin
            bitCntNxt = bitCnt + 1'b1;
          end else if (ev.sclFall) begin
            if (bitCnt == LAST_CNT) begin
              cmd.sdaRelease = 1'b1;
              stateNxt       = ST_MACK;
            end else begin
              cmd.txShift = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (ev.sclRise && ev.sdaBit) begin
            stateNxt = ST_IDLE;
          end else if (ev.sclFall) begin
            cmd.txLoad = 1'b1;
            bitCntNxt  = '0;
            stateNxt   = ST_TX;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
      isRead <= isReadNxt;
    end
  end

endmodule

// File: rtl/chansel_dp.sv
module chansel_dp
  import chansel_pkg::*;
#(
  parameter int              NUM_CH      = 2,
  parameter int              PIN_W       = 2,
  parameter int              PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11100,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [PIN_W-1:0]  addrPins,
  input  logic [NUM_CH-1:0] intN,
  input  dpCmd_t            cmd,
  output busEv_t            ev,
  output logic              sdaOe,
  output logic              intOutN,
  output logic [NUM_CH-1:0] chanEn
);

  localparam int BYTE_W = 8;
  localparam int ADDR_W = PREFIX_W + PIN_W;
  localparam int PAD_W  = BYTE_W - NUM_CH;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] rxByte, txByte, readVal;
  logic [NUM_CH-1:0] ctrlReg, pendReg;
  logic pendValid;

  // bus line synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  assign ev.startEv = sclS && sclPrev && sdaPrev && !sdaS;
  assign ev.stopEv  = sclS && sclPrev && !sdaPrev && sdaS;
  assign ev.sclRise = sclS && !sclPrev;
  assign ev.sclFall = !sclS && sclPrev;
  assign ev.sdaBit  = sdaS;
  assign ev.addrHit = (rxByte[BYTE_W-1:1] == ADDR_W'({ADDR_PREFIX, addrPins}));
  assign ev.rwBit   = rxByte[0];

  assign readVal = {{PAD_W{1'b0}}, ctrlReg};

  // shift registers and open-drain driver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txByte <= '0;
      sdaOe  <= 1'b0;
    end else begin
      if (cmd.rxShift) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (cmd.txLoad) txByte <= readVal;
      else if (cmd.txShift) txByte <= {txByte[BYTE_W-2:0], 1'b1};
      if (cmd.busClear || cmd.sdaRelease) sdaOe <= 1'b0;
      else if (cmd.txLoad) sdaOe <= !readVal[BYTE_W-1];
      else if (cmd.txShift) sdaOe <= !txByte[BYTE_W-2];
      else if (cmd.ackOn) sdaOe <= 1'b1;
    end
  end

  // staged and applied selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      pendReg   <= '0;
      pendValid <= 1'b0;
    end else if (cmd.busClear) begin
      ctrlReg   <= '0;
      pendReg   <= '0;
      pendValid <= 1'b0;
    end else begin
      if (cmd.stage) begin
        pendReg   <= rxByte[NUM_CH-1:0];
        pendValid <= 1'b1;
      end else if (cmd.commit) begin
        if (pendValid) ctrlReg <= pendReg;
        pendValid <= 1'b0;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign chanEn[ch] = ctrlReg[ch];
  end

  assign intOutN = &intN;

endmodule

// File: rtl/bus_chan_selector.sv
module bus_chan_selector
  import chansel_pkg::*;
#(
  parameter int                  NUM_CH      = 2,
  parameter int                  PIN_W       = 2,
  parameter int                  PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [PIN_W-1:0]  addrPins,
  input  logic [NUM_CH-1:0] intN,
  output logic              intOutN,
  output logic [NUM_CH-1:0] chanEn
);

  dpCmd_t cmd;
  busEv_t ev;

  chansel_ctrl #(.BYTE_BITS(8)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busRstN(busRstN),
    .ev     (ev),
    .cmd    (cmd)
  );

  chansel_dp #(
    .NUM_CH     (NUM_CH),
    .PIN_W      (PIN_W),
    .PREFIX_W   (PREFIX_W),
    .ADDR_PREFIX(ADDR_PREFIX),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .addrPins(addrPins),
    .intN    (intN),
    .cmd     (cmd),
    .ev      (ev),
    .sdaOe   (sdaOe),
    .intOutN (intOutN),
    .chanEn  (chanEn)
  );

endmodule

// File: rtl/chansel_checker.sv
module chansel_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busRstN,
  input logic              sclIn,
  input logic [NUM_CH-1:0] intN,
  input logic              intOutN,
  input logic [NUM_CH-1:0] chanEn,
  input logic              sdaOe
);

  // R3: power-on reset holds every channel off and SDA released
  assert_reset_state_R3: assert property (@(posedge clk)
    !rstN |-> (chanEn == '0 && !sdaOe));

  // R4: bus-recovery reset clears enables and releases SDA
  assert_bus_recover_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busRstN |=> (chanEn == '0 && !sdaOe));

  // R2: enables only move on a STOP, which needs SCL high on the synced samples
  assert_apply_at_stop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(chanEn) && $past(busRstN)) |-> ($past(sclIn, 3) && $past(sclIn, 4)));

  // R8: SDA is only pulled low while SCL is low
  assert_drive_on_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclIn, 3));

  // R5: any active channel interrupt asserts the merged output
  assert_int_any_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intN != '1) |-> !intOutN);

  // R5: merged output idles high when no channel requests
  assert_int_none_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intN == '1) |-> intOutN);

endmodule

bind bus_chan_selector chansel_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busRstN(busRstN),
  .sclIn  (sclIn),
  .intN   (intN),
  .intOutN(intOutN),
  .chanEn (chanEn),
  .sdaOe  (sdaOe)
);

// File: tb/bus_chan_selector_test.sv
module bus_chan_selector_test;

  localparam logic [4:0] PREFIX = 5'b11100;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rstN, busRstN, sclIn, sdaMst, sdaLine, sdaOe, intOutN;
  logic [1:0] addrPins, intN, chanEn;
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sdaLine = sdaMst & ~sdaOe;

  bus_chan_selector #(.ADDR_PREFIX(PREFIX)) uut (
    .clk(clk), .rstN(rstN), .busRstN(busRstN), .sclIn(sclIn), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .addrPins(addrPins), .intN(intN), .intOutN(intOutN), .chanEn(chanEn)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaMst = 1'b1; tick(Q);
    sclIn = 1'b1; tick(Q);
    sdaMst = 1'b0; tick(Q);
    sclIn = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaMst = 1'b0; tick(Q);
    sclIn = 1'b1; tick(Q);
    sdaMst = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaMst = b; tick(Q);
    sclIn = 1'b1; tick(2 * Q);
    sclIn = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaMst = 1'b1; tick(Q);
    sclIn = 1'b1; tick(Q);
    ack = !sdaLine;
    tick(Q);
    sclIn = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] v);
    sdaMst = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      sclIn = 1'b1; tick(Q);
      v[i] = sdaLine;
      tick(Q);
      sclIn = 1'b0; tick(Q);
    end
    sendBit(!mAck);
    sdaMst = 1'b1;
  endtask

  function automatic logic [7:0] addrByte(input logic [1:0] pins, input logic rd);
    return {PREFIX, pins, rd};
  endfunction

  task automatic writeReg(input logic [1:0] pins, input logic [7:0] d, output bit aAck, output bit dAck);
    busStart();
    sendByte(addrByte(pins, 1'b0), aAck);
    sendByte(d, dAck);
    busStop();
    tick(Q);
  endtask

  task automatic testReset();
    check("R3 chanEn after power-on", {6'b0, chanEn}, 8'h00);
    check("R3 sdaOe after power-on", {7'b0, sdaOe}, 8'h00);
  endtask

  task automatic testSelectAll();
    bit a, d;
    logic [7:0] pat [4] = '{8'h01, 8'h03, 8'h00, 8'h02};
    for (int k = 0; k < 4; k++) begin
      writeReg(2'b00, pat[k], a, d);
      check("R6 address ack", {7'b0, a}, 8'h01);
      check("R7 data ack", {7'b0, d}, 8'h01);
      check("R1 channel enables", {6'b0, chanEn}, pat[k] & 8'h03);
    end
  endtask

  task automatic testStaging();
    bit a, d;
    logic [7:0] v;
    writeReg(2'b00, 8'h03, a, d);
    busStart();
    sendByte(addrByte(2'b00, 1'b0), a);
    sendByte(8'h01, d);
    tick(Q);
    check("R2 held before STOP", {6'b0, chanEn}, 8'h03);
    busStart();
    sendByte(addrByte(2'b00, 1'b1), a);
    check("R2 read address ack", {7'b0, a}, 8'h01);
    recvByte(1'b0, v);
    check("R2 read in same transaction returns old value", v, 8'h03);
    check("R2 still held after repeated START", {6'b0, chanEn}, 8'h03);
    busStop();
    tick(Q);
    check("R2 applied at STOP", {6'b0, chanEn}, 8'h01);
  endtask

  task automatic testMultiByte();
    bit a, d1, d2;
    busStart();
    sendByte(addrByte(2'b00, 1'b0), a);
    sendByte(8'h02, d1);
    sendByte(8'hFF, d2);
    check("R7 second data byte ack", {7'b0, d2}, 8'h01);
    busStop();
    tick(Q);
    check("R7 last byte applied", {6'b0, chanEn}, 8'h03);
  endtask

  task automatic testAbortedByte();
    bit a, d;
    busStart();
    sendByte(addrByte(2'b00, 1'b0), a);
    sendByte(8'h02, d);
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    busStart();
    sendByte(addrByte(2'b00, 1'b0), a);
    check("R9 address ack after repeated START", {7'b0, a}, 8'h01);
    busStop();
    tick(Q);
    check("R9 partial byte discarded", {6'b0, chanEn}, 8'h02);
  endtask

  task automatic testRead();
    bit a, d;
    logic [7:0] v1, v2;
    writeReg(2'b00, 8'hFD, a, d);
    busStart();
    sendByte(addrByte(2'b00, 1'b1), a);
    recvByte(1'b1, v1);
    recvByte(1'b0, v2);
    check("R8 first read byte, upper bits zero", v1, 8'h01);
    check("R8 repeated read byte", v2, 8'h01);
    tick(Q);
    check("R8 SDA released after NACK", {7'b0, sdaOe}, 8'h00);
    busStop();
    tick(Q);
    check("R8 read leaves enables", {6'b0, chanEn}, 8'h01);
  endtask

  task automatic testAddrPins();
    bit a, d;
    addrPins = 2'b01;
    tick(Q);
    writeReg(2'b00, 8'h02, a, d);
    check("R6 stale address NACK", {7'b0, a}, 8'h00);
    check("R6 unmatched write ignored", {6'b0, chanEn}, 8'h01);
    writeReg(2'b01, 8'h02, a, d);
    check("R6 new pin address ack", {7'b0, a}, 8'h01);
    check("R6 new pin address write", {6'b0, chanEn}, 8'h02);
    addrPins = 2'b00;
    tick(Q);
  endtask

  task automatic testBusReset();
    bit a, d;
    writeReg(2'b00, 8'h03, a, d);
    busStart();
    sendByte(addrByte(2'b00, 1'b0), a);
    sendByte(8'h01, d);
    busRstN = 1'b0;
    tick(4);
    check("R4 enables cleared", {6'b0, chanEn}, 8'h00);
    check("R4 SDA released", {7'b0, sdaOe}, 8'h00);
    busRstN = 1'b1;
    tick(Q);
    busStop();
    tick(Q);
    check("R4 staged byte discarded", {6'b0, chanEn}, 8'h00);
    writeReg(2'b00, 8'h02, a, d);
    check("R4 recovery then ack", {7'b0, a}, 8'h01);
    check("R4 recovery then write", {6'b0, chanEn}, 8'h02);
  endtask

  task automatic testIntMerge();
    for (int k = 0; k < 4; k++) begin
      intN = 2'(k);
      tick(2);
      check("R5 merged interrupt", {7'b0, intOutN}, (k == 3) ? 8'h01 : 8'h00);
    end
    intN = 2'b11;
  endtask

  initial begin
    rstN = 1'b0; busRstN = 1'b1; sclIn = 1'b1; sdaMst = 1'b1;
    addrPins = 2'b00; intN = 2'b11;
    tick(5);
    testReset();
    rstN = 1'b1;
    tick(5);
    testReset();
    testSelectAll();
    testStaging();
    testMultiByte();
    testAbortedByte();
    testRead();
    testAddrPins();
    testBusReset();
    testIntMerge();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule